// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width and returns a quotient and a remainder. It works by the non-restoring method. A signed partial remainder, one bit wider than the operands, is doubled each step and takes in the next dividend bit. The divisor is then subtracted from it when it was non-negative, or added to it when it was negative. The sign of the new partial remainder gives the next quotient bit. The adder reads the partial remainder and the top dividend bit directly, in shifted alignment, so no separate shift cycle is needed. The first step always subtracts, because the partial remainder is cleared when an operation is accepted.

A caller pulses `start` with the operands while the block is idle. The block captures them in that cycle, which is the initialisation cycle. It then runs `W/K` step cycles, with `K` steps chained combinationally in each clock, and raises `done` for one cycle. A negative final partial remainder has the divisor added back in a correction adder at the output, so the correction costs no extra cycle. A zero divisor does not hang the block: the operation completes with the usual latency and `div_zero` is raised. The results stay on the outputs until the next operation is accepted.

Top module: `nrdiv_core`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled high at a rising edge while `busy` is 0 is accepted. `busy` is 1 from the next cycle until the cycle in which `done` is 1.
- R3: If `start` is accepted at rising edge n, `done` is 1 in the cycle that begins at rising edge n+W/K and 0 in the cycles before it. With W=8 this is 8 edges for K=1 and 2 edges for K=4.
- R4: For a non-zero divisor, when `done` is 1, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. This holds for every dividend, including 0 and the all-ones value.
- R5: `done` stays high for exactly one cycle per accepted operation.
- R6: A `start` that arrives while `busy` is 1 is ignored. The running operation keeps its operands, its result and its completion cycle.
- R7: A zero divisor completes with the latency of R3, and `div_zero` is 1 from the `done` cycle until the next accepted start. For a non-zero divisor, `div_zero` is 0.
- R8: When the final partial remainder is negative, the divisor is added back once, so the reported remainder is always below the divisor. Example: 100/7 gives quotient 14 and remainder 2.
- R9: Quotient and remainder are the same for K=1 and K=4; only the latency differs, as given in R3.
- R10: A `start` sampled in the cycle in which `done` is 1 is accepted. The finished result can be read in that cycle, and the new operation completes W/K edges later.
- R11: Quotient, remainder and `div_zero` hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while idle |
| dividend | input | W | Unsigned dividend, sampled on acceptance |
| divisor | input | W | Unsigned divisor, sampled on acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient of the last operation |
| remainder | output | W | Corrected remainder of the last operation |
| div_zero | output | 1 | Last operation had a zero divisor |

## Verification
Two functions can fall in the same cycle: the completion of one operation and the acceptance of the next one. This happens when `start` is high while `done` is high. The bench provokes it by raising `start` in the done cycle. It checks that the finished result is correct in that cycle, and that the new operands then produce their own correct result exactly W/K edges later. A second collision, a start pulse in the middle of a running operation, is judged by checking that the result and the completion cycle are those of the first operands.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } nrdiv_state_t;
endpackage

// File: rtl/nrdiv_step.sv
// One non-restoring iteration: doubles the partial remainder and shifts in the next
// dividend bit, then adds or subtracts the divisor according to the previous sign.
module nrdiv_step #(
  parameter int W = 8
) (
  input  logic [W:0]   p_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  output logic [W:0]   p_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] q_o
);
  logic [W:0] shifted;
  logic [W:0] dext;

  always_comb begin
    // Adder reads the partial remainder in shifted alignment: no separate shift cycle.
    shifted = {p_i[W-1:0], a_i[W-1]};
    dext    = {1'b0, d_i};
    p_o     = p_i[W] ? (shifted + dext) : (shifted - dext);
    a_o     = {a_i[W-2:0], 1'b0};
    q_o     = {q_i[W-2:0], ~p_o[W]};
  end
endmodule

// File: rtl/nrdiv_fix.sv
// Output correction: a negative final partial remainder gets the divisor added back.
module nrdiv_fix #(
  parameter int W = 8
) (
  input  logic [W:0]   p_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] r_o
);
  logic [W:0] restored;

  always_comb begin
    restored = p_i + {1'b0, d_i};
    r_o      = p_i[W] ? restored[W-1:0] : p_i[W-1:0];
  end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic busy,
  output logic done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  nrdiv_state_t st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_n;

  always_comb begin
    load    = (st_q == ST_IDLE) && start;
    step_en = (st_q == ST_RUN);
    st_n    = st_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    if (load) begin
      st_n  = ST_RUN;
      cnt_n = '0;
    end else if (step_en) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(N - 1)) begin
        st_n   = ST_IDLE;
        cnt_n  = '0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  logic done_q;
  assign done = done_q;
  assign busy = (st_q == ST_RUN);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
endmodule

// File: rtl/nrdiv_core.sv
module nrdiv_core #(
  parameter int W = 8,
  parameter int K = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  localparam int N  = W / K;
  localparam int LW = $clog2(N + 1);

  logic load, step_en, en;

  logic [W:0]   p_q, p_n;
  logic [W-1:0] a_q, a_n;
  logic [W-1:0] q_q, q_n;
  logic [W-1:0] d_q, d_n;
  logic         z_q, z_n;

  logic [W:0]   p_c [K+1];
  logic [W-1:0] a_c [K+1];
  logic [W-1:0] q_c [K+1];

  nrdiv_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load    (load),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  assign p_c[0] = p_q;
  assign a_c[0] = a_q;
  assign q_c[0] = q_q;

  for (genvar g = 0; g < K; g++) begin : g_chain
    nrdiv_step #(.W(W)) u_step (
      .p_i (p_c[g]),
      .a_i (a_c[g]),
      .q_i (q_c[g]),
      .d_i (d_q),
      .p_o (p_c[g+1]),
      .a_o (a_c[g+1]),
      .q_o (q_c[g+1])
    );
  end

  assign en = load | step_en;

  always_comb begin
    if (load) begin
      p_n = '0;
      a_n = dividend;
      q_n = '0;
      d_n = divisor;
      z_n = (divisor == '0);
    end else begin
      p_n = p_c[K];
      a_n = a_c[K];
      q_n = q_c[K];
      d_n = d_q;
      z_n = z_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      a_q <= '0;
      q_q <= '0;
      d_q <= '0;
      z_q <= 1'b0;
    end else if (en) begin
      p_q <= p_n;
      a_q <= a_n;
      q_q <= q_n;
      d_q <= d_n;
      z_q <= z_n;
    end
  end

  nrdiv_fix #(.W(W)) u_fix (
    .p_i (p_q),
    .d_i (d_q),
    .r_o (remainder)
  );

  assign quotient = q_q;
  assign div_zero = z_q;

  // Cycle counter kept for the latency check only.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (load)    lat_q <= '0;
    else if (step_en) lat_q <= lat_q + 1'b1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(N))); // R3

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(d_q)); // R6

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < d_q)); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_zero == (d_q == '0))); // R7

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder))); // R11
endmodule

// File: tb/sim_nrdiv_core.sv
module sim_nrdiv_core;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st0 = 1'b0, st1 = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic busy0, done0, dz0, busy1, done1, dz1;
  logic [W-1:0] q0, r0, q1, r1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nrdiv_core #(.W(W), .K(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(st0), .dividend(dvd), .divisor(dvs),
    .busy(busy0), .done(done0), .quotient(q0), .remainder(r0), .div_zero(dz0));

  nrdiv_core #(.W(W), .K(4)) u1 (
    .clk(clk), .rst_n(rst_n), .start(st1), .dividend(dvd), .divisor(dvs),
    .busy(busy1), .done(done1), .quotient(q1), .remainder(r1), .div_zero(dz1));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one division on both instances; checks latency, pulse width and results.
  task automatic run_div(input int a, input int b, input string req);
    int t0 = -1, t1 = -1;
    int cq0 = 0, cr0 = 0, cz0 = 0, cq1 = 0, cr1 = 0, cz1 = 0;
    @(negedge clk);
    dvd = W'(a); dvs = W'(b); st0 = 1'b1; st1 = 1'b1;
    @(negedge clk);
    st0 = 1'b0; st1 = 1'b0;
    chk("R2", "busy after accept", int'(busy0), 1);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (done0) begin
        if (t0 >= 0) chk("R5", "done0 repeated", j, t0);
        else begin t0 = j; cq0 = q0; cr0 = r0; cz0 = dz0; end
      end
      if (done1) begin
        if (t1 >= 0) chk("R5", "done1 repeated", j, t1);
        else begin t1 = j; cq1 = q1; cr1 = r1; cz1 = dz1; end
      end
    end
    chk("R3", "K=1 latency", t0, 8);
    chk("R9", "K=4 latency", t1, 2);
    chk("R7", "div_zero", cz0, (b == 0) ? 1 : 0);
    chk("R7", "div_zero K=4", cz1, (b == 0) ? 1 : 0);
    if (b != 0) begin
      chk(req, "quotient", cq0, a / b);
      chk(req, "remainder", cr0, a % b);
      chk("R9", "quotient K=4", cq1, a / b);
      chk("R9", "remainder K=4", cr1, a % b);
    end
    chk("R11", "quotient held", int'(q0), cq0);
    chk("R11", "div_zero held", int'(dz0), cz0);
  endtask

  task automatic t_reset;
    chk("R1", "busy", int'(busy0), 0);
    chk("R1", "done", int'(done0), 0);
    chk("R1", "div_zero", int'(dz0), 0);
    chk("R1", "quotient", int'(q0), 0);
    chk("R1", "remainder", int'(r0), 0);
  endtask

  // A start in the middle of an operation must not disturb it.
  task automatic t_busy_ignore;
    int t0 = -1;
    @(negedge clk);
    dvd = 8'd200; dvs = 8'd3; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (j == 3) begin dvd = 8'd9; dvs = 8'd4; st0 = 1'b1; end
      if (j == 4) st0 = 1'b0;
      if (done0 && t0 < 0) begin
        t0 = j;
        chk("R6", "quotient", int'(q0), 66);
        chk("R6", "remainder", int'(r0), 2);
      end
    end
    chk("R6", "completion cycle", t0, 8);
    chk("R6", "idle after", int'(busy0), 0);
  endtask

  // A start raised in the done cycle is accepted while the old result is read.
  task automatic t_back_to_back;
    int t0 = -1;
    @(negedge clk);
    dvd = 8'd100; dvs = 8'd7; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0;
    for (int j = 1; j <= 8; j++) @(negedge clk);
    chk("R10", "first done", int'(done0), 1);
    chk("R10", "first quotient", int'(q0), 14);
    chk("R8", "first remainder", int'(r0), 2);
    dvd = 8'd250; dvs = 8'd9; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0;
    chk("R10", "second accepted", int'(busy0), 1);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (done0 && t0 < 0) begin
        t0 = j;
        chk("R10", "second quotient", int'(q0), 27);
        chk("R10", "second remainder", int'(r0), 7);
      end
    end
    chk("R10", "second latency", t0, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_div(100, 7, "R8");
    run_div(255, 1, "R4");
    run_div(0, 9, "R4");
    run_div(13, 200, "R8");
    run_div(255, 255, "R4");
    run_div(128, 127, "R4");
    run_div(5, 5, "R4");
    run_div(77, 0, "R7");
    for (int a = 3; a < 256; a += 61)
      for (int b = 1; b < 256; b += 47)
        run_div(a, b, "R4");
    t_busy_ignore();
    t_back_to_back();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule